// File: doc/BRIEF.md
# Runtime-Configurable Asynchronous Serial Transmitter

This block turns one parallel character into one asynchronous serial frame on a single output line. The line rests at logic 1. A frame is a low start bit, the data bits sent least significant bit first, an optional parity bit, and a high stop interval. The character arrives through a valid/ready handshake. While a frame is on the line, the block holds its ready output low, so it holds at most one character.

Inputs that can change between frames set the format. They choose 7 or 8 data bits, one of five parity modes, and a stop interval of one, one and a half, or two bit periods. A divider input sets the length of a sub-tick, and each bit period is sixteen sub-ticks. The block captures the character, the format and the divider in the cycle it accepts the character. Changes on those inputs during a frame only affect the next frame.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset, and at any time no frame is in progress, `tx_line` is 1 and `in_ready` is 1.
- R2: A character is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. In the next cycle `tx_line` is 0 (start bit) and `in_ready` is 0.
- R3: A sub-tick lasts `div_val`+1 clock cycles, and every bit period lasts 16 sub-ticks.
- R4: After the start bit, the data bits follow with bit 0 first. `cfg_len8`=1 sends `in_data[7:0]` and `cfg_len8`=0 sends `in_data[6:0]`.
- R5: `cfg_par` selects the parity bit that follows the last data bit. 0 means no parity bit. 1 means even: the bit makes the count of ones over the data bits and the parity bit even. 2 means odd. 3 forces the bit to 1 and 4 forces it to 0. Codes 5 to 7 act as 0.
- R6: `cfg_stop` selects the stop interval at logic 1: 0 gives 16 sub-ticks, 1 gives 24 sub-ticks, and 2 or 3 give 32 sub-ticks.
- R7: `in_ready` rises again exactly when the stop interval ends. The whole frame therefore lasts (16·(1+L+P)+S)·(`div_val`+1) clock cycles, where L is the number of data bits, P is 1 when a parity bit is present, and S is the stop length in sub-ticks. An 8-bit frame with no parity and one stop bit lasts 160 sub-ticks, which is ten bit periods.
- R8: `in_data`, `cfg_len8`, `cfg_par`, `cfg_stop` and `div_val` are captured at acceptance. Changes on these inputs during a frame do not alter that frame.
- R9: If `in_valid` is 1 when `in_ready` rises, the next character is accepted at the following edge. Its start bit then begins immediately after the previous stop interval, with no extra idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Sub-tick length minus one, in clock cycles |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop interval code |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The bench runs every combination of data length, parity mode and stop length with several data patterns. It compares the line against a waveform computed in the bench, one clock cycle at a time. A design that counted the half-bit stop interval wrongly would release ready early or late. Even and odd parity computed over a seven-bit character that still included bit 7 would show up as a wrong parity bit for data 0x80 and 0xFF. During every frame the bench scrambles the data, format and divider inputs, so a design that did not capture them would change its waveform part way through the frame. Back-to-back frames check that the start bit follows the stop interval directly, and the unused parity and stop codes are checked as well.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int MAX_DATA = 8;
  localparam int FRAME_W  = MAX_DATA + 3;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'd0,
    STOP_ONE_HALF = 2'd1,
    STOP_TWO      = 2'd2
  } stop_mode_e;
endpackage

// File: rtl/stx_tick_gen.sv
module stx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div_lat,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    tick  = run && (cnt_q == div_lat);
    if (restart) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div_lat));
  assert_tick_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> (cnt_q == '0));
endmodule

// File: rtl/stx_frame_build.sv
module stx_frame_build
  import stx_pkg::*;
#(
  parameter int OVS_LOG2 = 4,
  parameter int CNT_W    = 8
) (
  input  logic [MAX_DATA-1:0] data,
  input  logic                len8,
  input  logic [2:0]          par,
  input  logic [1:0]          stop,
  output logic [FRAME_W-1:0]  frame_bits,
  output logic [CNT_W-1:0]    total_ticks
);
  localparam int OVS = 1 << OVS_LOG2;

  int                  ndata;
  int                  stop_ticks;
  logic                par_on;
  logic                par_bit;
  logic [MAX_DATA-1:0] data_m;

  always_comb begin
    ndata  = len8 ? MAX_DATA : MAX_DATA - 1;
    data_m = len8 ? data : {1'b0, data[MAX_DATA-2:0]};
    par_on  = 1'b1;
    par_bit = 1'b0;
    case (par)
      PAR_EVEN:  par_bit = ^data_m;
      PAR_ODD:   par_bit = ~(^data_m);
      PAR_MARK:  par_bit = 1'b1;
      PAR_SPACE: par_bit = 1'b0;
      default:   par_on  = 1'b0;
    endcase
    case (stop)
      STOP_ONE:      stop_ticks = OVS;
      STOP_ONE_HALF: stop_ticks = OVS + OVS / 2;
      default:       stop_ticks = 2 * OVS;
    endcase

    frame_bits    = '1;
    frame_bits[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < ndata) frame_bits[i+1] = data_m[i];
    end
    if (par_on) frame_bits[ndata+1] = par_bit;

    total_ticks = CNT_W'((1 + ndata + int'(par_on)) * OVS + stop_ticks);
  end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int OVS_LOG2 = 4,
  parameter int CNT_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic [CNT_W-1:0]   total_ticks,
  input  logic               tick,
  output logic               busy,
  output logic               line_bit
);
  logic                busy_q, busy_d;
  logic [FRAME_W-1:0]  sh_q, sh_d;
  logic [OVS_LOG2-1:0] phase_q, phase_d;
  logic [CNT_W-1:0]    left_q, left_d;

  always_comb begin
    busy_d  = busy_q;
    sh_d    = sh_q;
    phase_d = phase_q;
    left_d  = left_q;
    if (load) begin
      busy_d  = 1'b1;
      sh_d    = frame_bits;
      phase_d = '0;
      left_d  = total_ticks;
    end else if (busy_q && tick) begin
      left_d  = left_q - 1'b1;
      phase_d = phase_q + 1'b1;
      if (phase_q == '1) sh_d = {1'b1, sh_q[FRAME_W-1:1]};
      if (left_q == CNT_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sh_q    <= '1;
      phase_q <= '0;
      left_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      sh_q    <= sh_d;
      phase_q <= phase_d;
      left_q  <= left_d;
    end
  end

  assign busy     = busy_q;
  assign line_bit = busy_q ? sh_q[0] : 1'b1;

  assert_left_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0));
  assert_end_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(tick) && $past(left_q) == CNT_W'(1)));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import stx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OVS_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cfg_len8,
  input  logic [2:0]       cfg_par,
  input  logic [1:0]       cfg_stop,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             tx_line
);
  localparam int OVS   = 1 << OVS_LOG2;
  localparam int CNT_W = $clog2((FRAME_W + 2) * OVS + 1);

  logic               rst_meta, rst_sync_n;
  logic               accept, busy, tick, line_bit;
  logic [DIV_W-1:0]   div_q, div_d;
  logic [FRAME_W-1:0] frame_bits;
  logic [CNT_W-1:0]   total_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  always_comb begin
    div_d = div_q;
    if (accept) div_d = div_val;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) div_q <= '0;
    else             div_q <= div_d;
  end

  stx_frame_build #(.OVS_LOG2(OVS_LOG2), .CNT_W(CNT_W)) u_build (
    .data(in_data), .len8(cfg_len8), .par(cfg_par), .stop(cfg_stop),
    .frame_bits(frame_bits), .total_ticks(total_ticks)
  );

  stx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .restart(accept), .run(busy),
    .div_lat(div_q), .tick(tick)
  );

  stx_shifter #(.OVS_LOG2(OVS_LOG2), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .load(accept), .frame_bits(frame_bits),
    .total_ticks(total_ticks), .tick(tick), .busy(busy), .line_bit(line_bit)
  );

  assign tx_line = line_bit;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_ready |-> tx_line);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |=> (!tx_line && !in_ready));
  assert_div_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_ready && $past(!in_ready)) |-> $stable(div_q));
endmodule

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_val = '0;
  logic        cfg_len8 = 1'b1;
  logic [2:0]  cfg_par = '0;
  logic [1:0]  cfg_stop = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, tx_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .cfg_len8(cfg_len8),
    .cfg_par(cfg_par), .cfg_stop(cfg_stop), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .tx_line(tx_line)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit l8, input int p,
                      input int s, input int dv);
    int L, P, S, D, N, mode, bad, rdy_bad;
    logic [11:0] eb;
    logic par_b, first_ok;
    while (!in_ready) @(negedge clk);
    in_data = d; cfg_len8 = l8; cfg_par = 3'(p); cfg_stop = 2'(s);
    div_val = 16'(dv); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data = ~d; cfg_len8 = ~l8; cfg_par = 3'(p + 1); cfg_stop = 2'(s + 1);
    div_val = 16'(dv + 3);
    L = l8 ? 8 : 7;
    mode = (p > 4) ? 0 : p;
    P = (mode != 0) ? 1 : 0;
    S = (s == 0) ? 16 : (s == 1) ? 24 : 32;
    D = dv + 1;
    N = (16 * (1 + L + P) + S) * D;
    par_b = 1'b0;
    for (int i = 0; i < L; i++) par_b = par_b ^ d[i];
    if (mode == 2) par_b = ~par_b;
    if (mode == 3) par_b = 1'b1;
    if (mode == 4) par_b = 1'b0;
    eb = '1;
    eb[0] = 1'b0;
    for (int i = 0; i < L; i++) eb[i+1] = d[i];
    if (P == 1) eb[L+1] = par_b;
    first_ok = (tx_line == 1'b0) && (in_ready == 1'b0);
    chk(first_ok, "R2 start bit and ready low after accept", int'(tx_line), 0);
    bad = 0; rdy_bad = 0;
    for (int c = 0; c < N; c++) begin
      int idx;
      logic e;
      idx = c / (16 * D);
      e = (idx < 12) ? eb[idx] : 1'b1;
      if (tx_line !== e) bad++;
      if (in_ready !== 1'b0) rdy_bad++;
      @(negedge clk);
    end
    chk(bad == 0, $sformatf("R4 R5 R6 R3 R8 waveform d=%02h l8=%0d p=%0d s=%0d dv=%0d", d, l8, p, s, dv),
        bad, 0);
    chk(rdy_bad == 0 && in_ready == 1'b1 && tx_line == 1'b1,
        $sformatf("R7 frame length %0d cycles", N), rdy_bad, 0);
  endtask

  initial begin
    logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1 && tx_line == 1'b1, "R1 reset state", int'(tx_line), 1);

    begin
      int hi = 0;
      for (int c = 0; c < 40; c++) begin
        if (tx_line == 1'b1 && in_ready == 1'b1) hi++;
        @(negedge clk);
      end
      chk(hi == 40, "R1 idle line high", hi, 40);
    end

    for (int l = 0; l < 2; l++)
      for (int p = 0; p < 5; p++)
        for (int s = 0; s < 3; s++)
          foreach (pats[k]) send(pats[k], l[0], p, s, 0);

    send(8'h41, 1'b1, 0, 0, 2);
    send(8'h3C, 1'b0, 1, 1, 1);
    send(8'hC3, 1'b1, 2, 2, 3);
    send(8'h7E, 1'b1, 6, 3, 2);
    send(8'h01, 1'b0, 7, 3, 0);
    send(8'h96, 1'b1, 1, 1, 4);

    // R9: back-to-back frames with no gap
    in_data = 8'h55; cfg_len8 = 1'b1; cfg_par = 3'd0; cfg_stop = 2'd0; div_val = '0;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    begin
      int n = 0;
      while (in_ready == 1'b0 && n < 400) begin n++; @(negedge clk); end
      chk(n == 160, "R7 8N1 frame is 160 sub-ticks", n, 160);
      @(negedge clk);
      chk(tx_line == 1'b0 && in_ready == 1'b0, "R9 next start bit follows stop directly",
          int'(tx_line), 0);
      in_valid = 1'b0;
    end
    while (!in_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(tx_line == 1'b1, "R1 idle after back-to-back", int'(tx_line), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule